// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache

This block sits between a processor word port and a block-oriented main-memory port. A processor word address is cut into three fields: a tag in the upper bits, a line index in the middle, and a word-in-block offset in the lowest bits. The block number (address shifted right by the offset width) selects exactly one line, the block number modulo the number of lines. Each line holds a valid bit, a dirty bit, a tag and one block of data words.

A lookup compares the tag held in the indexed line with the tag of the request. On a hit the word is read or written locally, and the access completes one cycle later. On a miss the line is given to the new block. If the old occupant was modified, its block is first written out, then the new block is read beat by beat. The requested word is handed to the processor as soon as its beat arrives, while the rest of the line keeps filling. Write misses allocate the line and merge the processor word into the incoming block.

The default parameters give a 16-bit word address, a 4-bit index (16 lines), 4-word blocks and 32-bit words. A 24-bit address with a 14-bit index is reached through the same parameters.

Top module: `dmc_cache`

## Requirements
- R1: The address is {tag, index, offset} with the offset in the low OFF_W bits and the index in the next IDX_W bits. Block number b = addr >> OFF_W is held in line b mod 2^IDX_W, so blocks with distinct indexes coexist and all hit after being loaded.
- R2: Reset clears every valid bit and leaves cpu_ready_o and mem_valid_o low, so the first access to any line misses.
- R3: A read whose tag matches a valid line raises cpu_ready_o in the cycle after the edge that takes the request, with the stored word on cpu_rdata_o and no memory traffic. cpu_ready_o is never raised while no request was held in the previous cycle.
- R4: A write hit stores cpu_wdata_i in the addressed word, marks the line dirty, completes with the same one-cycle timing and causes no memory traffic.
- R5: A miss reads the new block as 2^OFF_W beats with mem_we_o low, at word addresses block_base+0, +1, ... in ascending order. When the victim is clean or invalid, no write beat occurs.
- R6: A miss on a valid dirty line first writes the victim block as 2^OFF_W beats with mem_we_o high, at the victim's own tag and index, offsets ascending, carrying the latest data. All write beats complete before the first read beat.
- R7: On a refill, cpu_ready_o pulses in the cycle after the read beat whose offset equals the request offset. For a read, that beat's word is on cpu_rdata_o. The remaining beats then continue.
- R8: A write miss allocates the line, replaces the requested word of the fetched block with cpu_wdata_i and marks the line dirty. Other words keep the memory values, and a later eviction writes the merged block out.
- R9: cpu_ready_o is a single-cycle pulse. A request present in the cycle where cpu_ready_o is high is not taken at the next edge, only at the one after. New requests are taken only once a refill has finished.
- R10: Two blocks with the same index and different tags evict each other, and every access alternating between them misses.
- R11: A write beat completes at an edge where mem_valid_o, mem_we_o and mem_ready_i are high. A read beat completes where mem_valid_o is high, mem_we_o is low and mem_rvalid_i is high. Until a beat completes, mem_valid_o, mem_we_o, mem_addr_o and, for writes, mem_wdata_o are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until cpu_ready_o |
| cpu_we_i | input | 1 | Request is a write |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with cpu_ready_o |
| mem_valid_o | output | 1 | Memory beat requested |
| mem_we_o | output | 1 | Beat is a write-back |
| mem_addr_o | output | ADDR_W | Word address of the beat |
| mem_wdata_o | output | DATA_W | Write-back data |
| mem_ready_i | input | 1 | Memory accepts the write beat |
| mem_rvalid_i | input | 1 | Read beat data is valid |
| mem_rdata_i | input | DATA_W | Read beat data |

## Verification
Two things can happen in the same cycle. In the first case, the last refill beat writes the line and delivers the forwarded word, and the pulse then coincides with the cache going idle. The bench provokes this with misses whose offset is the last word of the block. It then presents the next request in the very cycle of the pulse and expects it to complete exactly one cycle later than a fresh request would. In the second case, a write miss merges the processor word into the beat that fills that word. This is judged by reading the other words of the block and by forcing a later eviction, where the write-back data must carry the merged value. Memory stalls on both beat kinds are injected so that the held-beat rule is checked while these events overlap.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [TAG_W-1:0]  tag_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [OFF_W-1:0]  off_o
);
    assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
    assign idx_o = addr_i[OFF_W +: IDX_W];
    assign off_o = addr_i[OFF_W-1:0];
endmodule

// File: rtl/dmc_meta_store.sv
module dmc_meta_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 10,
    localparam int LINES = 1 << IDX_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_valid_o,
    output logic             rd_dirty_o,
    output logic [TAG_W-1:0] rd_tag_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  logic             wr_dirty_i,
    input  logic             mark_en_i,
    input  logic [IDX_W-1:0] mark_idx_i
);
    logic [LINES-1:0] valid_all;
    logic [LINES-1:0] dirty_all;
    logic [TAG_W-1:0] tag_all [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             v_q;
        logic             d_q;
        logic [TAG_W-1:0] t_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                t_q <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                v_q <= 1'b1;
                d_q <= wr_dirty_i;
                t_q <= wr_tag_i;
            end else if (mark_en_i && (mark_idx_i == IDX_W'(g))) begin
                d_q <= 1'b1;
            end
        end

        assign valid_all[g] = v_q;
        assign dirty_all[g] = d_q;
        assign tag_all[g]   = t_q;
    end

    assign rd_valid_o = valid_all[rd_idx_i];
    assign rd_dirty_o = dirty_all[rd_idx_i];
    assign rd_tag_o   = tag_all[rd_idx_i];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << (IDX_W + OFF_W)
) (
    input  logic              clk_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i
);
    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (wr_en_i) begin
            words_q[{wr_idx_i, wr_off_i}] <= wr_data_i;
        end
    end

    assign rd_data_o = words_q[{rd_idx_i, rd_off_i}];
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              cpu_ready_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              mem_valid_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ready_i,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    typedef struct packed {
        ctl_state_e        st;
        logic [OFF_W-1:0]  beat;
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic              rdy;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [TAG_W-1:0] req_tag, lat_tag, meta_tag, meta_wr_tag;
    logic [IDX_W-1:0] req_idx, lat_idx, look_idx, meta_wr_idx, mark_idx;
    logic [OFF_W-1:0] req_off, lat_off, look_off, dat_wr_off;
    logic             meta_valid, meta_dirty, meta_wr_en, meta_wr_dirty, mark_en;
    logic             dat_wr_en, hit, take;
    logic [IDX_W-1:0] dat_wr_idx;
    logic [DATA_W-1:0] dat_rd, dat_wr_data, fill_word;

    dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_req (
        .addr_i(cpu_addr_i), .tag_o(req_tag), .idx_o(req_idx), .off_o(req_off)
    );

    dmc_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_lat (
        .addr_i(c_q.addr), .tag_o(lat_tag), .idx_o(lat_idx), .off_o(lat_off)
    );

    assign look_idx = (c_q.st == ST_IDLE) ? req_idx : lat_idx;
    assign look_off = (c_q.st == ST_IDLE) ? req_off : c_q.beat;

    dmc_meta_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_meta (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .rd_idx_i(look_idx), .rd_valid_o(meta_valid), .rd_dirty_o(meta_dirty), .rd_tag_o(meta_tag),
        .wr_en_i(meta_wr_en), .wr_idx_i(meta_wr_idx), .wr_tag_i(meta_wr_tag), .wr_dirty_i(meta_wr_dirty),
        .mark_en_i(mark_en), .mark_idx_i(mark_idx)
    );

    dmc_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
        .clk_i(clk_i),
        .rd_idx_i(look_idx), .rd_off_i(look_off), .rd_data_o(dat_rd),
        .wr_en_i(dat_wr_en), .wr_idx_i(dat_wr_idx), .wr_off_i(dat_wr_off), .wr_data_i(dat_wr_data)
    );

    assign hit  = meta_valid && (meta_tag == req_tag);
    assign take = cpu_req_i && !c_q.rdy && (c_q.st == ST_IDLE);
    assign fill_word = (c_q.we && (c_q.beat == lat_off)) ? c_q.wdata : mem_rdata_i;

    always_comb begin
        c_d           = c_q;
        c_d.rdy       = 1'b0;
        meta_wr_en    = 1'b0;
        meta_wr_idx   = lat_idx;
        meta_wr_tag   = lat_tag;
        meta_wr_dirty = c_q.we;
        mark_en       = 1'b0;
        mark_idx      = req_idx;
        dat_wr_en     = 1'b0;
        dat_wr_idx    = lat_idx;
        dat_wr_off    = c_q.beat;
        dat_wr_data   = fill_word;
        mem_valid_o   = 1'b0;
        mem_we_o      = 1'b0;
        mem_addr_o    = {lat_tag, lat_idx, c_q.beat};
        mem_wdata_o   = dat_rd;

        unique case (c_q.st)
            ST_IDLE: begin
                if (take) begin
                    if (hit) begin
                        c_d.rdy   = 1'b1;
                        c_d.rdata = cpu_we_i ? cpu_wdata_i : dat_rd;
                        if (cpu_we_i) begin
                            dat_wr_en   = 1'b1;
                            dat_wr_idx  = req_idx;
                            dat_wr_off  = req_off;
                            dat_wr_data = cpu_wdata_i;
                            mark_en     = 1'b1;
                        end
                    end else begin
                        c_d.addr  = cpu_addr_i;
                        c_d.we    = cpu_we_i;
                        c_d.wdata = cpu_wdata_i;
                        c_d.beat  = '0;
                        c_d.st    = (meta_valid && meta_dirty) ? ST_EVICT : ST_REFILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_valid_o = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = {meta_tag, lat_idx, c_q.beat};
                if (mem_ready_i) begin
                    c_d.beat = c_q.beat + 1'b1;
                    if (c_q.beat == '1) begin
                        c_d.st = ST_REFILL;
                    end
                end
            end
            ST_REFILL: begin
                mem_valid_o = 1'b1;
                if (mem_rvalid_i) begin
                    dat_wr_en = 1'b1;
                    c_d.beat  = c_q.beat + 1'b1;
                    if (c_q.beat == lat_off) begin
                        c_d.rdy   = 1'b1;
                        c_d.rdata = fill_word;
                    end
                    if (c_q.beat == '1) begin
                        meta_wr_en = 1'b1;
                        c_d.st     = ST_IDLE;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cpu_ready_o = c_q.rdy;
    assign cpu_rdata_o = c_q.rdata;
endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cpu_req_i,
    input logic              cpu_ready_o,
    input logic              mem_valid_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_ready_i,
    input logic              mem_rvalid_i
);
    logic beat_done, last_off;
    assign beat_done = mem_valid_o && ((mem_we_o && mem_ready_i) || (!mem_we_o && mem_rvalid_i));
    assign last_off  = (mem_addr_o[OFF_W-1:0] == '1);

    AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_ready_o |=> !cpu_ready_o); // R9

    AST_NO_UNASKED_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cpu_req_i |=> !cpu_ready_o); // R3

    AST_WRITE_BEAT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_valid_o && mem_we_o && !mem_ready_i)
        |=> (mem_valid_o && mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o))); // R11

    AST_READ_BEAT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_valid_o && !mem_we_o && !mem_rvalid_i)
        |=> (mem_valid_o && !mem_we_o && $stable(mem_addr_o))); // R11

    AST_BEAT_ASCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (beat_done && !last_off)
        |=> (mem_valid_o && (mem_addr_o == $past(mem_addr_o) + 1'b1))); // R5

    AST_EVICT_UNBROKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_valid_o && mem_we_o && mem_ready_i && !last_off)
        |=> (mem_valid_o && mem_we_o)); // R6

    AST_EVICT_THEN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_valid_o && mem_we_o && mem_ready_i && last_off)
        |=> (mem_valid_o && !mem_we_o && (mem_addr_o[OFF_W-1:0] == '0))); // R6
endmodule

bind dmc_cache dmc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_ready_o(cpu_ready_o),
    .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rvalid_i(mem_rvalid_i)
);

// File: tb/dmc_cache_test.sv
`timescale 1ns/1ps
module dmc_cache_test;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int IW = 4;
    localparam int OW = 2;
    localparam int NL = 1 << IW;
    localparam int NB = 1 << OW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready_o;
    logic [DW-1:0] cpu_rdata_o;
    logic          mem_valid_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic          mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    dmc_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .OFF_W(OW)) uut (
        .clk_i(clk), .rst_ni(rst_n),
        .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
        .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
        .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready), .mem_rvalid_i(mem_rvalid),
        .mem_rdata_i(mem_rdata)
    );

    int total = 0;
    int bad = 0;
    logic [DW-1:0] gold [int];
    logic [DW-1:0] mainmem [int];
    int ref_blk [NL];
    bit ref_dirty [NL];
    int stall_mod = 0;
    int stall_ctr = 0;

    function automatic logic [DW-1:0] seed_val(int a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [DW-1:0] rd_gold(int a);
        return gold.exists(a) ? gold[a] : seed_val(a);
    endfunction

    function automatic logic [DW-1:0] rd_main(int a);
        return mainmem.exists(a) ? mainmem[a] : seed_val(a);
    endfunction

    function automatic bit allow();
        stall_ctr++;
        return (stall_mod == 0) || ((stall_ctr % stall_mod) != 0);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(bit we, logic [AW-1:0] a, logic [DW-1:0] wd, string lbl);
        int blk = int'(a) >> OW;
        int line = blk % NL;
        int off = int'(a) % NB;
        bit hit = (ref_blk[line] == blk);
        bit want_wb = !hit && (ref_blk[line] >= 0) && ref_dirty[line];
        int victim = ref_blk[line];
        bit prev_rdy = cpu_ready_o;
        int cyc = 0;
        int wbn = 0;
        int rdn = 0;
        bit got = 0;
        bit fwd_due = 0;
        bit pend = 0;
        bit gave;
        bit exp_rdy;
        logic [AW-1:0] pend_addr = '0;
        bit pend_we = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (got) begin
                chk(!cpu_ready_o, "R9", 32'(cpu_ready_o), 0, "repeated ready");
            end else if (hit) begin
                exp_rdy = (cyc == 1 + int'(prev_rdy));
                chk(cpu_ready_o == exp_rdy, prev_rdy ? "R9" : (we ? "R4" : "R3"),
                    32'(cpu_ready_o), 32'(exp_rdy), "hit ready timing");
            end else begin
                chk(cpu_ready_o == fwd_due, "R7", 32'(cpu_ready_o), 32'(fwd_due), "forward ready timing");
            end
            fwd_due = 0;
            if (cpu_ready_o && !got) begin
                got = 1;
                cpu_req = 1'b0;
                if (!we) chk(cpu_rdata_o == rd_gold(int'(a)), lbl, cpu_rdata_o, rd_gold(int'(a)), "read data");
            end
            mem_ready = 1'b0; mem_rvalid = 1'b0; gave = 0;
            if (pend) chk(mem_valid_o && (mem_addr_o == pend_addr) && (mem_we_o == pend_we), "R11",
                          32'(mem_addr_o), 32'(pend_addr), "stalled beat held");
            pend = 0;
            if (mem_valid_o) begin
                if (hit) begin
                    chk(0, we ? "R4" : "R3", 32'(mem_addr_o), 0, "memory traffic on hit");
                end else if (mem_we_o) begin
                    chk(want_wb && (rdn == 0) && (wbn < NB), "R6", 32'(wbn), 32'(rdn), "write beat order");
                    chk(mem_addr_o == AW'(victim * NB + wbn), "R6", 32'(mem_addr_o), 32'(victim * NB + wbn), "write beat address");
                    chk(mem_wdata_o == rd_gold(int'(mem_addr_o)), "R6", mem_wdata_o, rd_gold(int'(mem_addr_o)), "write beat data");
                    if (allow()) begin
                        mem_ready = 1'b1;
                        mainmem[int'(mem_addr_o)] = mem_wdata_o;
                        wbn++; gave = 1;
                    end
                end else begin
                    chk((rdn < NB) && (wbn == (want_wb ? NB : 0)), want_wb ? "R6" : "R5", 32'(wbn), 32'(want_wb ? NB : 0), "read after write-back");
                    chk(mem_addr_o == AW'(blk * NB + rdn), "R5", 32'(mem_addr_o), 32'(blk * NB + rdn), "read beat address");
                    if (allow()) begin
                        mem_rvalid = 1'b1;
                        mem_rdata = rd_main(int'(mem_addr_o));
                        if (rdn == off) fwd_due = 1;
                        rdn++; gave = 1;
                    end
                end
                if (!gave) begin pend = 1; pend_addr = mem_addr_o; pend_we = mem_we_o; end
            end
            if (got && !gave && (hit || rdn == NB)) break;
            if (cyc > 300) begin
                chk(0, lbl, 32'(cyc), 0, "access never completed");
                cpu_req = 1'b0; mem_ready = 1'b0; mem_rvalid = 1'b0;
                break;
            end
        end
        chk(rdn == (hit ? 0 : NB), lbl, 32'(rdn), 32'(hit ? 0 : NB), hit ? "beats on hit" : "beats on miss");
        if (!hit) begin
            ref_blk[line] = blk;
            ref_dirty[line] = we;
        end else if (we) begin
            ref_dirty[line] = 1'b1;
        end
        if (we) gold[int'(a)] = wd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R3", 0, 1, "watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) begin ref_blk[i] = -1; ref_dirty[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ready_o && !mem_valid_o, "R2", {cpu_ready_o, mem_valid_o}, 0, "outputs idle after reset");

        // cold miss, hits, back-to-back hit
        access(0, 16'h0000, '0, "R2");
        access(0, 16'h0003, '0, "R3");
        access(0, 16'h0001, '0, "R9");
        access(1, 16'h0002, 32'hCAFE_0002, "R4");
        access(0, 16'h0002, '0, "R4");
        // forwarding at middle and last offsets
        access(0, 16'h01D6, '0, "R7");
        access(0, 16'h01DB, '0, "R7");
        access(0, 16'h01D4, '0, "R7");
        // conflicting blocks on line 3
        for (int k = 0; k < 3; k++) begin
            access(0, 16'h004D, '0, "R10");
            access(0, 16'h008C, '0, "R10");
        end
        // write miss, dirty eviction, read back
        access(1, 16'h004D, 32'h1234_5678, "R8");
        access(0, 16'h008C, '0, "R6");
        access(0, 16'h004D, '0, "R8");
        access(1, 16'h00E6, 32'hA5A5_0E6E, "R8");
        access(0, 16'h00E4, '0, "R8");
        access(0, 16'h00E6, '0, "R8");
        // stalled memory with dirty victims
        stall_mod = 3;
        access(0, 16'h0165, '0, "R11");
        access(1, 16'h00E7, 32'h0BAD_F00D, "R11");
        access(0, 16'h0165, '0, "R11");
        access(0, 16'h00E7, '0, "R11");
        stall_mod = 2;
        access(1, 16'h0147, 32'h7777_0147, "R11");
        access(0, 16'h00E5, '0, "R11");
        // index mapping sweep
        stall_mod = 0;
        for (int i = 0; i < NL; i++) access(0, AW'((16'h3FF << 6) | (i << 2) | 3), '0, "R1");
        for (int i = 0; i < NL; i++) access(0, AW'((16'h3FF << 6) | (i << 2)), '0, "R1");
        for (int i = 0; i < NL; i++) access(1, AW'((16'h3FF << 6) | (i << 2) | 1), 32'(i * 32'h0101_0101), "R1");
        stall_mod = 4;
        for (int i = 0; i < NL; i++) access(0, AW'((16'h0AB << 6) | (i << 2) | (i % NB)), '0, "R6");
        stall_mod = 0;
        for (int i = 0; i < NL; i++) access(0, AW'((16'h3FF << 6) | (i << 2) | 1), '0, "R8");
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule